// File: doc/BRIEF.md
# Bus Transfer Strobe Generator

This block turns the state sequencer's current state code and the decoder's machine-cycle type code into the three external bus timing strobes of an 8-bit processor. The three strobes are a cycle-start marker, a read enable that tells the outside world to drive the data bus, and an active-low write strobe. Which data strobe fires is chosen by the class of the machine cycle. A read-class cycle opens the read enable. A write-class cycle pulls the write strobe low. The remaining cycle types produce only the cycle-start marker. Both data strobes stretch by one clock for every wait state that the sequencer inserts.

All three outputs come from flops, and each shows the state that was presented one clock earlier. The cycle type is sampled while the sequencer presents the first state of a machine cycle and is held for the rest of that cycle. The decoder can therefore move on to its next code without disturbing a transfer in progress. While hold is acknowledged, the outputs go quiet on the next clock. The same is true in reset.

State codes used by the sequencer: T1=0, T2=1, T3=2, T4=3, T5=4, wait=5, halt-wait=6, idle=7. Cycle type codes: fetch=0, memory read=1, memory write=2, stack read=3, stack write=4, input=5, output=6, interrupt acknowledge=7, halt=8, halt-with-interrupt=9. Codes 10 to 15 are unused.

Top module: `bus_strobe_gen`

## Requirements
- R1: While rst_n is low, sync_o and dbin_o are 0 and wr_n_o is 1.
- R2: sync_o is 1 in the clock after state code 0 (T1) is presented, and in no other clock.
- R3: For cycle types 0, 1, 3 and 7, dbin_o is 1 in the clock after state code 1 (T2) is presented and in the clock after each wait state (code 5). It is 0 otherwise.
- R4: For cycle types 2, 4 and 6, wr_n_o is 0 in the clock after each wait state (code 5) and in the clock after state code 2 (T3). It is 1 otherwise.
- R5: Each wait state lengthens the active data strobe by exactly one clock. A read with three waits gives four clocks of dbin_o. A write with two waits gives three clocks of wr_n_o low.
- R6: The cycle type is captured from mc_type_i only when state code 0 is presented. Changes on mc_type_i during later states do not change the strobes of that machine cycle.
- R7: Cycle types 5, 8 and 9 and the unused codes 10 to 15 never raise dbin_o and never pull wr_n_o low.
- R8: When hold_ack_i is 1, the next clock shows sync_o=0, dbin_o=0 and wr_n_o=1, whatever the state.
- R9: dbin_o=1 and wr_n_o=0 never occur in the same clock.
- R10: States T4, T5, halt-wait and idle (codes 3, 4, 6, 7) produce no strobe in the following clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_state_i | input | 3 | Current sequencer state code |
| mc_type_i | input | 4 | Machine-cycle type code from the decoder |
| hold_ack_i | input | 1 | Hold acknowledged; silences all strobes |
| sync_o | output | 1 | Cycle-start marker |
| dbin_o | output | 1 | Data-bus read enable |
| wr_n_o | output | 1 | Active-low write strobe |

## Verification
Every strobe is due exactly one clock after the state, type and hold inputs that cause it. The bench drives those inputs on a falling edge and lets one rising edge pass. It then compares all three outputs on the next falling edge against a bench model of that one cycle. The model keeps its own copy of the type captured at T1, updated on the same edge as the design's copy, so a type change after T1 is expected to have no effect. The wait-stretch checks count strobe clocks across a whole directed machine cycle, sampled at the same falling edges.

// File: rtl/bst_pkg.sv
package bst_pkg;

    localparam int ST_W   = 3;
    localparam int TYPE_W = 4;

    typedef enum logic [ST_W-1:0] {
        ST_T1   = 3'd0,
        ST_T2   = 3'd1,
        ST_T3   = 3'd2,
        ST_T4   = 3'd3,
        ST_T5   = 3'd4,
        ST_TW   = 3'd5,
        ST_TWH  = 3'd6,
        ST_IDLE = 3'd7
    } mc_state_e;

    typedef enum logic [TYPE_W-1:0] {
        CT_FETCH   = 4'd0,
        CT_MRD     = 4'd1,
        CT_MWR     = 4'd2,
        CT_SRD     = 4'd3,
        CT_SWR     = 4'd4,
        CT_IN      = 4'd5,
        CT_OUT     = 4'd6,
        CT_INTA    = 4'd7,
        CT_HALT    = 4'd8,
        CT_HALTINT = 4'd9,
        CT_NONE    = 4'd15
    } cyc_type_e;

    typedef struct packed {
        logic sync;
        logic dbin;
        logic wr;
    } strobe_t;

endpackage

// File: rtl/bst_type_latch.sv
module bst_type_latch #(
    parameter int TYPE_W = 4,
    parameter logic [TYPE_W-1:0] RESET_CODE = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic [TYPE_W-1:0] type_i,
    output logic [TYPE_W-1:0] type_o
);

    logic [TYPE_W-1:0] type_d, type_q;

    always_comb begin
        type_d = type_q;
        if (capture_i) begin
            type_d = type_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            type_q <= RESET_CODE;
        end else begin
            type_q <= type_d;
        end
    end

    assign type_o = type_q;

endmodule

// File: rtl/bst_cycle_class.sv
module bst_cycle_class #(
    parameter int TYPE_W = 4,
    localparam int NUM_CODES = 1 << TYPE_W,
    parameter logic [NUM_CODES-1:0] RD_MASK = 16'h008B,
    parameter logic [NUM_CODES-1:0] WR_MASK = 16'h0054
) (
    input  logic [TYPE_W-1:0] type_i,
    output logic              is_rd_o,
    output logic              is_wr_o
);

    logic [NUM_CODES-1:0] code_hot;

    for (genvar c = 0; c < NUM_CODES; c++) begin : g_code
        assign code_hot[c] = (type_i == TYPE_W'(c));
    end

    assign is_rd_o = |(code_hot & RD_MASK);
    assign is_wr_o = |(code_hot & WR_MASK);

endmodule

// File: rtl/bst_strobe_core.sv
module bst_strobe_core
    import bst_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ST_W-1:0] st_i,
    input  logic            is_rd_i,
    input  logic            is_wr_i,
    input  logic            hold_i,
    output logic            sync_o,
    output logic            dbin_o,
    output logic            wr_o
);

    strobe_t stb_d, stb_q;

    always_comb begin
        stb_d = '0;
        if (!hold_i) begin
            stb_d.sync = (st_i == ST_T1);
            stb_d.dbin = is_rd_i && ((st_i == ST_T2) || (st_i == ST_TW));
            stb_d.wr   = is_wr_i && ((st_i == ST_TW) || (st_i == ST_T3));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stb_q <= '0;
        end else begin
            stb_q <= stb_d;
        end
    end

    assign sync_o = stb_q.sync;
    assign dbin_o = stb_q.dbin;
    assign wr_o   = stb_q.wr;

    AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(stb_q.dbin && stb_q.wr)); // R9
    AST_HOLD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (stb_q == '0)); // R8
    AST_SYNC_MARKS_T1: assert property (@(posedge clk) disable iff (!rst_n)
        stb_q.sync |-> $past(st_i == ST_T1)); // R2

endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
    import bst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ST_W-1:0]   mc_state_i,
    input  logic [TYPE_W-1:0] mc_type_i,
    input  logic              hold_ack_i,
    output logic              sync_o,
    output logic              dbin_o,
    output logic              wr_n_o
);

    logic [TYPE_W-1:0] type_q;
    logic              is_rd, is_wr, wr_act;

    bst_type_latch #(
        .TYPE_W     (TYPE_W),
        .RESET_CODE (CT_NONE)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (mc_state_i == ST_T1),
        .type_i    (mc_type_i),
        .type_o    (type_q)
    );

    bst_cycle_class #(
        .TYPE_W (TYPE_W)
    ) u_class (
        .type_i  (type_q),
        .is_rd_o (is_rd),
        .is_wr_o (is_wr)
    );

    bst_strobe_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .st_i    (mc_state_i),
        .is_rd_i (is_rd),
        .is_wr_i (is_wr),
        .hold_i  (hold_ack_i),
        .sync_o  (sync_o),
        .dbin_o  (dbin_o),
        .wr_o    (wr_act)
    );

    assign wr_n_o = ~wr_act;

    AST_UNUSED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (type_q >= 4'd10 && mc_state_i != ST_T1) |=> (!dbin_o && wr_n_o)); // R7
    AST_TAIL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (mc_state_i == ST_T4 || mc_state_i == ST_T5 || mc_state_i == ST_TWH || mc_state_i == ST_IDLE)
        |=> (!sync_o && !dbin_o && wr_n_o)); // R10

endmodule

// File: tb/bus_strobe_gen_tb_top.sv
`timescale 1ns/1ps
module bus_strobe_gen_tb_top;
    import bst_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] st = 3'd7;
    logic [3:0] ty = 4'd0;
    logic       hd = 1'b0;
    logic       sync_o, dbin_o, wr_n_o;

    int checks = 0;
    int errors = 0;
    logic [3:0] m_lat = 4'd15;
    int cnt_dbin, cnt_wr;

    always #2.5 clk = ~clk;

    bus_strobe_gen dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mc_state_i (st),
        .mc_type_i  (ty),
        .hold_ack_i (hd),
        .sync_o     (sync_o),
        .dbin_o     (dbin_o),
        .wr_n_o     (wr_n_o)
    );

    function automatic logic m_rd(input logic [3:0] t);
        return (t == 4'd0 || t == 4'd1 || t == 4'd3 || t == 4'd7);
    endfunction

    function automatic logic m_wr(input logic [3:0] t);
        return (t == 4'd2 || t == 4'd4 || t == 4'd6);
    endfunction

    task automatic chk(input string tag, input string sig, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, sig, act, exp, $time);
        end
    endtask

    // one clock: drive on a falling edge, check the registered result one falling edge later
    task automatic cyc(input logic [2:0] s, input logic [3:0] t, input logic h, input string tag);
        logic e_sync, e_dbin, e_wrn;
        st = s; ty = t; hd = h;
        e_sync = !h && (s == 3'd0);
        e_dbin = !h && m_rd(m_lat) && (s == 3'd1 || s == 3'd5);
        e_wrn  = !(!h && m_wr(m_lat) && (s == 3'd5 || s == 3'd2));
        if (s == 3'd0) m_lat = t;
        @(negedge clk);
        chk((tag != "") ? tag : "R2", "sync", sync_o, e_sync);
        chk((tag != "") ? tag : "R3", "dbin", dbin_o, e_dbin);
        chk((tag != "") ? tag : "R4", "wr_n", wr_n_o, e_wrn);
        chk("R9", "overlap", dbin_o && !wr_n_o, 1'b0);
        if (dbin_o) cnt_dbin++;
        if (!wr_n_o) cnt_wr++;
    endtask

    initial begin : watchdog
        #(100000 * 5);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        int seed;
        seed = 1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        chk("R1", "sync", sync_o, 1'b0);
        chk("R1", "dbin", dbin_o, 1'b0);
        chk("R1", "wr_n", wr_n_o, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: read with three waits
        cnt_dbin = 0;
        cyc(3'd0, 4'd1, 1'b0, "R2");
        cyc(3'd1, 4'd9, 1'b0, "R3");
        repeat (3) cyc(3'd5, 4'd9, 1'b0, "R5");
        cyc(3'd2, 4'd9, 1'b0, "R3");
        chk("R5", "dbin_len", (cnt_dbin == 4), 1'b1);

        // R5: write with two waits
        cnt_wr = 0;
        cyc(3'd0, 4'd4, 1'b0, "R2");
        cyc(3'd1, 4'd1, 1'b0, "R4");
        repeat (2) cyc(3'd5, 4'd1, 1'b0, "R5");
        cyc(3'd2, 4'd1, 1'b0, "R4");
        cyc(3'd3, 4'd1, 1'b0, "R10");
        chk("R5", "wr_len", (cnt_wr == 3), 1'b1);

        // R6: type changes after T1 are ignored
        cnt_wr = 0; cnt_dbin = 0;
        cyc(3'd0, 4'd1, 1'b0, "R6");
        cyc(3'd1, 4'd2, 1'b0, "R6");
        cyc(3'd2, 4'd6, 1'b0, "R6");
        chk("R6", "no_write", (cnt_wr == 0 && cnt_dbin == 1), 1'b1);

        // R7: input, halt and unused codes stay silent
        for (int c = 5; c < 16; c++) begin
            if (c == 6 || c == 7) continue;
            cnt_wr = 0; cnt_dbin = 0;
            cyc(3'd0, 4'(c), 1'b0, "R7");
            cyc(3'd1, 4'(c), 1'b0, "R7");
            cyc(3'd5, 4'(c), 1'b0, "R7");
            cyc(3'd2, 4'(c), 1'b0, "R7");
            chk("R7", "silent", (cnt_wr == 0 && cnt_dbin == 0), 1'b1);
        end

        // R8: hold silences a write mid-cycle
        cyc(3'd0, 4'd6, 1'b0, "R2");
        cyc(3'd1, 4'd6, 1'b1, "R8");
        cyc(3'd5, 4'd6, 1'b1, "R8");
        cyc(3'd2, 4'd6, 1'b0, "R4");

        // R10: tail and halt states
        cyc(3'd0, 4'd0, 1'b0, "R2");
        cyc(3'd4, 4'd0, 1'b0, "R10");
        cyc(3'd6, 4'd0, 1'b0, "R10");
        cyc(3'd7, 4'd0, 1'b0, "R10");

        // random machine cycles
        for (int n = 0; n < 400; n++) begin
            logic [3:0] t0;
            int waits, tail;
            t0 = 4'($urandom % 16);
            cyc(3'd0, t0, ($urandom % 8) == 0, "");
            cyc(3'd1, 4'($urandom % 16), ($urandom % 8) == 0, "");
            waits = $urandom % 4;
            for (int w = 0; w < waits; w++) cyc(3'd5, 4'($urandom % 16), ($urandom % 8) == 0, "R5");
            cyc(3'd2, 4'($urandom % 16), ($urandom % 8) == 0, "");
            tail = $urandom % 3;
            if (tail > 0) cyc(3'd3, 4'($urandom % 16), 1'b0, "R10");
            if (tail > 1) cyc(3'd4, 4'($urandom % 16), 1'b0, "R10");
            if (($urandom % 16) == 0) cyc(3'd6, 4'($urandom % 16), 1'b0, "R10");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule